// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block turns single-word requests from on-chip logic into correctly timed cycles on an external asynchronous static RAM of 8192 words by 8 bits. A request carries a read/write flag, a 13-bit address and 8 bits of write data. The controller registers the request, then sequences the two chip selects, the write strobe, the output-enable strobe and the data-bus direction. Each minimum time is given in nanoseconds and turned into a whole number of clock cycles from a clock-period parameter. The rule is ceiling division, with a floor of one cycle.

The request side uses a valid/ready handshake. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so one access is in flight at a time. A requester that sees `req_ready` low must hold its request until it is taken. A request withdrawn before `req_ready` rises is never performed. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that marks the end of each access. For a read, `rsp_rdata` holds the word from that pulse until the next read completes.

The bidirectional memory bus appears as three plain ports: output data, output enable and input data. The pad ring combines them into the tri-state lines.

Top module: `sramc_top`

## Requirements
- R1: After reset, `sram_ce1_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0. The same select and strobe levels and a released bus hold in every idle cycle.
- R2: A request is accepted only in a cycle with `req_valid`=1 and `req_ready`=1. `req_ready` is 0 from the next cycle until the cycle in which the response pulse appears. A request raised and dropped while `req_ready`=0 has no effect on the memory or on the responses.
- R3: A write asserts `sram_ce1_n`=0 and `sram_ce2`=1 with the write strobe high for one setup cycle. It then holds `sram_we_n`=0 while both selects stay active and `sram_oe_n` stays 1.
- R4: `sram_dq_oe` is 1 only while `sram_oe_n`=1. It rises only after the write strobe has been low long enough for the memory's write-enable float time and output-enable float time. It stays high, with unchanged data, for at least the data setup time before the write strobe rises.
- R5: `sram_addr` is stable whenever the chip is selected in two consecutive cycles. The address is set at least the address-setup-to-write-end time before the write strobe rises.
- R6: A read holds `sram_ce1_n`=0, `sram_ce2`=1, `sram_oe_n`=0 and `sram_we_n`=1, and leaves the bus released. It samples `sram_dq_i` at the end of the last read cycle, no earlier than the larger of the address access time and the output-enable access time after the read began.
- R7: `rsp_valid` is high for exactly one cycle per access. With the default 8 ns clock it rises 5 clock edges after the accepting edge for a write and 3 edges after it for a read. For a read, `rsp_rdata` then equals the word stored at the address.
- R8: A write that follows a read does not drive the bus until the memory's output-enable float time has elapsed since `sram_oe_n` rose, so the two sides never drive the bus together.
- R9: Every cycle count is the ceiling of nanoseconds over clock period, at least 1. At the defaults, the write strobe is low for 3 cycles and a read holds output enable low for 3 cycles.
- R10: `rsp_rdata` keeps the last read word across later write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse at the end of an access |
| rsp_rdata | output | 8 | Last word read |
| sram_addr | output | 13 | Memory address lines |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_o | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data lines |
| sram_dq_i | input | 8 | Data from the memory |

## Verification
Suppose the phase register or the phase timer went wrong. The bench would see it at the first affected access, within a few cycles. The response pulse or `req_ready` would move off its computed cycle, or a strobe would be held too short or too long. A read phase that ends early captures the inverted word that the bench memory presents before the access time has elapsed. A bus enable raised too soon overlaps the memory's float window and is reported as contention in the cycle it happens. A lost or stray write shows up later, as a wrong word on the read-back of that address.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WSETUP, PH_WGAP, PH_WDATA, PH_WHOLD, PH_READ
  } phase_t;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic we_n;
    logic oe_n;
    logic drive;
  } pins_t;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // ceiling of ns / period, never below one cycle
  function automatic int ns2cyc(int ns, int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic pins_t pins_for(phase_t p);
    pins_t r;
    case (p)
      PH_WSETUP: r = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
      PH_WGAP:   r = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b0, oe_n: 1'b1, drive: 1'b0};
      PH_WDATA:  r = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
      PH_WHOLD:  r = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
      PH_READ:   r = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
      default:   r = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
`timescale 1ns/1ps
module sramc_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sramc_seq.sv
`timescale 1ns/1ps
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int CLK_NS    = 8,
  parameter int T_AA_NS   = 20,
  parameter int T_DOE_NS  = 10,
  parameter int T_PWE_NS  = 15,
  parameter int T_SD_NS   = 10,
  parameter int T_AW_NS   = 15,
  parameter int T_WC_NS   = 20,
  parameter int T_HZOE_NS = 8,
  parameter int T_HZWE_NS = 7,
  localparam int SETUP_C  = 1,
  localparam int GAP_C    = imax(ns2cyc(T_HZWE_NS, CLK_NS), ns2cyc(T_HZOE_NS, CLK_NS)),
  localparam int DATA_C   = imax(ns2cyc(T_SD_NS, CLK_NS),
                                 imax(ns2cyc(T_PWE_NS, CLK_NS),
                                      ns2cyc(T_AW_NS, CLK_NS) - SETUP_C) - GAP_C),
  localparam int HOLD_C   = imax(1, ns2cyc(T_WC_NS, CLK_NS) - SETUP_C - GAP_C - DATA_C),
  localparam int RD_C     = imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_DOE_NS, CLK_NS)),
  localparam int MAXLEN   = imax(imax(GAP_C, DATA_C), imax(HOLD_C, RD_C)),
  localparam int CNT_W    = $clog2(MAXLEN + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire,
  input  logic   is_write,
  output phase_t phase_q,
  output pins_t  pins_q,
  output logic   cap,
  output logic   done_q
);
  phase_t           phase_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;
  logic             done_d;

  sramc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    cap      = 1'b0;
    done_d   = 1'b0;
    case (phase_q)
      PH_IDLE: if (fire) begin
        load = 1'b1;
        if (is_write) begin
          phase_d  = PH_WSETUP;
          load_val = CNT_W'(SETUP_C - 1);
        end else begin
          phase_d  = PH_READ;
          load_val = CNT_W'(RD_C - 1);
        end
      end
      PH_WSETUP: if (expired) begin
        phase_d  = PH_WGAP;
        load     = 1'b1;
        load_val = CNT_W'(GAP_C - 1);
      end
      PH_WGAP: if (expired) begin
        phase_d  = PH_WDATA;
        load     = 1'b1;
        load_val = CNT_W'(DATA_C - 1);
      end
      PH_WDATA: if (expired) begin
        phase_d  = PH_WHOLD;
        load     = 1'b1;
        load_val = CNT_W'(HOLD_C - 1);
      end
      PH_WHOLD: if (expired) begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end
      PH_READ: if (expired) begin
        phase_d = PH_IDLE;
        cap     = 1'b1;
        done_d  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // pins are registered from the next phase so the pads see clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pins_q  <= pins_for(PH_IDLE);
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pins_q  <= pins_for(phase_d);
      done_q  <= done_d;
    end
  end

  // R3: the write strobe is only ever low while the chip is selected and not reading
  assert_we_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.we_n |-> (!pins_q.ce1_n && pins_q.ce2 && pins_q.oe_n));

  // R7: the response marker never lasts two cycles
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: the capture strobe only fires while output enable is low
  assert_capture_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> !pins_q.oe_n);
endmodule

// File: rtl/sramc_dpath.sv
`timescale 1ns/1ps
module sramc_dpath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              cap,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= dq_in;
  end
endmodule

// File: rtl/sramc_top.sv
`timescale 1ns/1ps
module sramc_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 8,
  parameter int T_AA_NS   = 20,
  parameter int T_DOE_NS  = 10,
  parameter int T_PWE_NS  = 15,
  parameter int T_SD_NS   = 10,
  parameter int T_AW_NS   = 15,
  parameter int T_WC_NS   = 20,
  parameter int T_HZOE_NS = 8,
  parameter int T_HZWE_NS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  phase_t phase;
  pins_t  pins;
  logic   cap;
  logic   fire;

  assign req_ready = (phase == PH_IDLE);
  assign fire      = req_valid && req_ready;

  sramc_seq #(
    .CLK_NS(CLK_NS), .T_AA_NS(T_AA_NS), .T_DOE_NS(T_DOE_NS), .T_PWE_NS(T_PWE_NS),
    .T_SD_NS(T_SD_NS), .T_AW_NS(T_AW_NS), .T_WC_NS(T_WC_NS),
    .T_HZOE_NS(T_HZOE_NS), .T_HZWE_NS(T_HZWE_NS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .is_write(req_write),
    .phase_q(phase), .pins_q(pins), .cap(cap), .done_q(rsp_valid)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .take(fire), .addr_in(req_addr), .wdata_in(req_wdata),
    .cap(cap), .dq_in(sram_dq_i), .addr_q(sram_addr), .wdata_q(sram_dq_o),
    .rdata_q(rsp_rdata)
  );

  assign sram_ce1_n = pins.ce1_n;
  assign sram_ce2   = pins.ce2;
  assign sram_we_n  = pins.we_n;
  assign sram_oe_n  = pins.oe_n;
  assign sram_dq_oe = pins.drive;

  // R4: the controller never drives while the memory's output enable is on
  assert_drive_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  // R4: the drive enable only rises after a cycle of write strobe low
  assert_drive_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> $past(!sram_we_n));

  // R5: address never moves while the chip stays selected
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce1_n && $past(!sram_ce1_n)) |-> $stable(sram_addr));

  // R2: while accepting, the memory is deselected and the bus is released
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && !sram_dq_oe && sram_we_n));
endmodule

// File: tb/sramc_top_tb.sv
`timescale 1ns/1ps
module sramc_top_tb;
  localparam int CLK = 8, AA = 20, PWE = 15, SD = 10, AW = 15, HZOE = 8, HZWE = 7;
  localparam int WR_LAT = 6, RD_LAT = 4;   // negedge offsets from the accepting negedge

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [12:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [12:0] sram_addr;
  logic sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0] sram_dq_o;
  logic [7:0] dq_mem = '0;

  always #4 clk = ~clk;

  sramc_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(dq_mem)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural memory and the bench's own expectation of its contents
  logic [7:0] mem [0:8191];
  logic [7:0] shadow [0:8191];

  int cyc = 0, busy_until = 0, rsp_due = -1;
  bit rsp_is_rd = 0;
  logic [7:0] rsp_exp = '0, last_rd = '0;
  int rd_cnt = 0, we_cnt = 0, oe_hi_cnt = 100, sd_cnt = 0, aw_cnt = 0;
  bit prev_we_n = 1, prev_oe_drv = 0;
  logic [12:0] prev_addr = '0;
  logic [7:0] prev_dq = '0;

  always @(negedge clk) if (rst_n && !finished) begin
    bit sel, exp_ready, hz_busy;
    sel = !sram_ce1_n && sram_ce2;
    exp_ready = (cyc >= busy_until);

    // reference comparisons on every clock
    chk(req_ready == exp_ready, "R2 ready", req_ready, exp_ready);
    chk(rsp_valid == (cyc == rsp_due), "R7 rsp_valid", rsp_valid, cyc == rsp_due);
    if (cyc == rsp_due) begin
      if (rsp_is_rd) chk(rsp_rdata == rsp_exp, "R7 read data", rsp_rdata, rsp_exp);
      else           chk(rsp_rdata == last_rd, "R10 rdata held", rsp_rdata, last_rd);
      if (rsp_is_rd) last_rd = rsp_exp;
    end
    if (exp_ready)
      chk({sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe} == 5'b10110,
          "R1 idle pins", {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);

    // memory model: strobe rules
    if (!sram_we_n)
      chk(sel && sram_oe_n, "R3 strobe while selected", {sel, sram_oe_n}, 2'b11);
    if (sram_dq_oe) chk(sram_oe_n, "R4 drive with oe high", sram_oe_n, 1);

    // write end on the rising write strobe
    if (sram_we_n && !prev_we_n) begin
      chk(we_cnt == 3, "R9 strobe cycles", we_cnt, 3);
      chk(we_cnt * CLK >= PWE, "R3 pulse width", we_cnt * CLK, PWE);
      chk(sd_cnt * CLK >= SD, "R4 data setup", sd_cnt * CLK, SD);
      chk(aw_cnt * CLK >= AW, "R5 address setup", aw_cnt * CLK, AW);
      chk(sram_addr == prev_addr, "R5 address hold", sram_addr, prev_addr);
      mem[prev_addr] = prev_dq;
    end
    if (!sram_oe_n && sram_oe_n !== 1'bx && sel && rd_cnt > 0 && rsp_valid == 0) begin end

    // float windows of the memory outputs
    if (sram_oe_n) oe_hi_cnt = (oe_hi_cnt < 100) ? oe_hi_cnt + 1 : oe_hi_cnt; else oe_hi_cnt = 0;
    if (sram_we_n) we_cnt = 0; else we_cnt++;
    hz_busy = (sel && sram_we_n && !sram_oe_n) ||
              (oe_hi_cnt > 0 && oe_hi_cnt * CLK - CLK / 2 < HZOE) ||
              (we_cnt > 0 && we_cnt * CLK - CLK / 2 < HZWE);
    chk(!(sram_dq_oe && hz_busy), "R8 bus contention", sram_dq_oe, 0);

    // counters for setup windows
    if (!sram_we_n && sram_dq_oe)
      sd_cnt = (prev_oe_drv && sram_dq_o == prev_dq) ? sd_cnt + 1 : 1;
    else if (sram_we_n) sd_cnt = 0;
    if (sel) aw_cnt = (aw_cnt > 0 && sram_addr == prev_addr) ? aw_cnt + 1 : 1; else aw_cnt = 0;

    // read path: inverted word until the access time has elapsed
    if (sel && sram_we_n && !sram_oe_n) begin
      rd_cnt = (rd_cnt > 0 && sram_addr == prev_addr) ? rd_cnt + 1 : 1;
      dq_mem = (rd_cnt * CLK - CLK / 2 >= AA) ? mem[sram_addr] : ~mem[sram_addr];
    end else begin
      if (rd_cnt > 0) chk(rd_cnt == 3, "R6 read cycles", rd_cnt, 3);
      rd_cnt = 0;
      dq_mem = 8'h00;
    end

    prev_we_n = sram_we_n;
    prev_oe_drv = sram_dq_oe;
    prev_addr = sram_addr;
    prev_dq = sram_dq_o;

    // acceptance seen at the ports: schedule the expected outcome
    if (req_valid && req_ready) begin
      rsp_is_rd = !req_write;
      rsp_due = cyc + (req_write ? WR_LAT : RD_LAT);
      busy_until = rsp_due;
      if (req_write) shadow[req_addr] = req_wdata;
      else rsp_exp = shadow[req_addr];
    end
    cyc++;
  end

  task automatic op(bit wr, logic [12:0] a, logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      if (req_ready && cyc > busy_until) break;
    end
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) begin
      mem[i] = 8'(i * 7) ^ 8'h3C;
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    chk({sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rsp_valid} == 7'b1011010,
        "R1 reset", {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rsp_valid},
        7'b1011010);
    @(posedge clk); #1; rst_n = 1;

    // writes of several patterns, including both ends of the address range
    op(1, 13'd0, 8'h00);    wait_idle();
    op(1, 13'd8191, 8'hFF); wait_idle();
    op(1, 13'd100, 8'h55);  wait_idle();
    op(1, 13'd4096, 8'hAA); wait_idle();
    op(0, 13'd0, 8'h0);     wait_idle();
    op(0, 13'd8191, 8'h0);  wait_idle();
    op(0, 13'd100, 8'h0);   wait_idle();
    op(0, 13'd4096, 8'h0);  wait_idle();
    op(0, 13'd777, 8'h0);   wait_idle();   // untouched location

    // R8: write straight after a read, then R10 rdata held across it
    op(0, 13'd4096, 8'h0);
    op(1, 13'd200, 8'h3C);
    op(0, 13'd200, 8'h0);
    op(1, 13'd201, 8'hC3);
    op(1, 13'd202, 8'h81);
    op(0, 13'd201, 8'h0);
    wait_idle();

    // R2: a request flashed while busy is ignored
    op(1, 13'd300, 8'h11);
    @(posedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = 13'd100; req_wdata = 8'hEE;
    @(posedge clk); #1;
    req_valid = 0;
    wait_idle();
    op(0, 13'd100, 8'h0); wait_idle();
    op(0, 13'd300, 8'h0); wait_idle();

    // sweep of mixed traffic
    for (int k = 0; k < 40; k++) begin
      op(k[0], 13'(k * 211 + 5), 8'(k * 37));
      if (k[2]) wait_idle();
    end
    wait_idle();
    for (int k = 0; k < 40; k++) op(0, 13'(k * 211 + 5), 8'h0);
    wait_idle();
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule